// File: doc/BRIEF.md
# Shift-Register Byte Aligner

The aligner takes a stream of wide input words, each made of byte lanes plus a count of unused lanes at the top, and packs the valid bytes back to back into full output words of the same width. Valid bytes always sit in the low lanes of an input word. The packed stream keeps arrival order, with lane 0 of each input word first.

Every accepted word is copied at fixed positions into the upper half of a register twice the word width. The register then moves down by one byte per cycle, once for each valid byte. When sixteen bytes have arrived, the lower half holds a finished output word, and a one-cycle valid strobe presents it. The input handshake holds the source off while shifting is in progress. A full word that arrives with nothing pending skips the shifting and appears on the next cycle.

Top module: `byte_aligner`

## Requirements
- R1: After reset, in_ready_o is high and out_valid_o is low.
- R2: A word is taken only on a cycle where in_valid_i and in_ready_o are both high. When the taken word is not on the bypass path, in_ready_o is low on the next cycle.
- R3: A taken word with in_empty_i = e, outside the bypass path, holds in_ready_o low for exactly LANES − e cycles. in_ready_o then returns high.
- R4: Output lane j, at bits [8j+7:8j], carries the j-th byte of the packed stream that starts at that output word. Input lane i, at bits [8i+7:8i], comes after input lane i−1 of the same word and before lane 0 of the next word.
- R5: Bytes left over once an output word fills carry into the following output word with no loss and no duplication, including bytes from one input word that span two output words.
- R6: A word with in_empty_i = 0 that arrives when no bytes are pending appears unchanged on out_data_o with out_valid_o high on the next cycle. in_ready_o stays high.
- R7: out_valid_o marks each finished word for one cycle. A strobe raised while in_ready_o is low is followed by a low cycle.
- R8: Input lanes at or above LANES − in_empty_i never reach the output.
- R9: in_valid_i and in_data_i on cycles where in_ready_o is low have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word offered |
| in_ready_o | output | 1 | Aligner can take a word |
| in_data_i | input | LANES*BYTE_W | Input lanes, lane 0 in the low byte |
| in_empty_i | input | $clog2(LANES) | Count of unused upper lanes |
| out_valid_o | output | 1 | Output word complete, one-cycle strobe |
| out_data_o | output | LANES*BYTE_W | Packed output word, earliest byte in lane 0 |

## Verification
A wrong byte count or shift counter shows up in two ways. The ready stall has the wrong length, which is visible on the cycle the source is released. The strobe also falls on the wrong shift, so every later output word is offset by whole lanes. A fault in the register wiring shows up as a wrong lane in the first word that passes through it. The stream is therefore compared word by word against a queue of every valid input byte, and the stall length is measured for each load. A sweep over all pairs of input byte counts covers every starting offset, so each possible split of one input word across an output boundary is exercised.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } align_state_e;
endpackage

// File: rtl/aligner_ctrl.sv
module aligner_ctrl
  import aligner_pkg::*;
#(
  parameter int LANES     = 16,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic [$clog2(LANES)-1:0] in_empty_i,
  output logic                     in_ready_o,
  output logic                     load_hi_o,
  output logic                     load_byp_o,
  output logic                     shift_o,
  output logic                     word_done_o
);
  localparam int CNT_W = $clog2(LANES + 1);

  align_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;   // bytes in current output word
  logic [CNT_W-1:0] rem_q, rem_d;   // shifts left for current input word
  logic             done_q, done_d;
  logic             accept, fast, cnt_last;
  logic [CNT_W-1:0] n_valid;

  assign accept   = (state_q == ST_IDLE) && in_valid_i;
  assign n_valid  = CNT_W'(LANES) - CNT_W'(in_empty_i);
  assign cnt_last = (cnt_q == CNT_W'(LANES - 1));

  generate
    if (BYPASS_EN) begin : g_byp
      assign fast = accept && (in_empty_i == '0) && (cnt_q == '0);
    end else begin : g_nobyp
      assign fast = 1'b0;
    end
  endgenerate

  assign in_ready_o  = (state_q == ST_IDLE);
  assign load_hi_o   = accept && !fast;
  assign load_byp_o  = fast;
  assign shift_o     = (state_q == ST_SHIFT);
  assign word_done_o = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    done_d  = fast;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && !fast) begin
          rem_d   = n_valid;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        rem_d = rem_q - CNT_W'(1);
        if (cnt_last) begin
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
        if (rem_q == CNT_W'(1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/aligner_shreg.sv
module aligner_shreg #(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_hi_i,
  input  logic                    load_byp_i,
  input  logic                    shift_i,
  input  logic [LANES*BYTE_W-1:0] in_data_i,
  output logic [LANES*BYTE_W-1:0] word_o
);
  localparam int POS = 2 * LANES;

  logic [BYTE_W-1:0] in_lane [LANES];
  logic [BYTE_W-1:0] sreg_q  [POS];
  logic [BYTE_W-1:0] sreg_d  [POS];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign in_lane[i]                 = in_data_i[i*BYTE_W +: BYTE_W];
      assign word_o[i*BYTE_W +: BYTE_W] = sreg_q[i];
    end
  endgenerate

  // fixed-position loads; each position sees at most one neighbour
  always_comb begin
    for (int p = 0; p < POS - 1; p++) begin
      sreg_d[p] = sreg_q[p];
      if (p < LANES) begin
        if (load_byp_i)   sreg_d[p] = in_lane[p];
        else if (shift_i) sreg_d[p] = sreg_q[p+1];
      end else begin
        if (load_hi_i)    sreg_d[p] = in_lane[p-LANES];
        else if (shift_i) sreg_d[p] = sreg_q[p+1];
      end
    end
    sreg_d[POS-1] = sreg_q[POS-1];
    if (load_hi_i)    sreg_d[POS-1] = in_lane[LANES-1];
    else if (shift_i) sreg_d[POS-1] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < POS; p++) sreg_q[p] <= '0;
    end else begin
      for (int p = 0; p < POS; p++) sreg_q[p] <= sreg_d[p];
    end
  end
endmodule

// File: rtl/byte_aligner.sv
module byte_aligner #(
  parameter int LANES     = 16,
  parameter int BYTE_W    = 8,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [LANES*BYTE_W-1:0]  in_data_i,
  input  logic [$clog2(LANES)-1:0] in_empty_i,
  output logic                     out_valid_o,
  output logic [LANES*BYTE_W-1:0]  out_data_o
);
  logic load_hi, load_byp, shift;

  aligner_ctrl #(
    .LANES    (LANES),
    .BYPASS_EN(BYPASS_EN)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_empty_i (in_empty_i),
    .in_ready_o (in_ready_o),
    .load_hi_o  (load_hi),
    .load_byp_o (load_byp),
    .shift_o    (shift),
    .word_done_o(out_valid_o)
  );

  aligner_shreg #(
    .LANES (LANES),
    .BYTE_W(BYTE_W)
  ) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_hi_i (load_hi),
    .load_byp_i(load_byp),
    .shift_i   (shift),
    .in_data_i (in_data_i),
    .word_o    (out_data_o)
  );
endmodule

// File: rtl/aligner_chk.sv
module aligner_chk #(
  parameter int LANES     = 16,
  parameter int BYTE_W    = 8,
  parameter bit BYPASS_EN = 1'b1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic                     in_ready_o,
  input logic [LANES*BYTE_W-1:0]  in_data_i,
  input logic [$clog2(LANES)-1:0] in_empty_i,
  input logic                     out_valid_o,
  input logic [LANES*BYTE_W-1:0]  out_data_o
);
  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0] busy_q, pend_q, n_in, sum;
  logic             take, fast;

  assign take = in_valid_i && in_ready_o;
  assign n_in = CNT_W'(LANES) - CNT_W'(in_empty_i);
  assign fast = BYPASS_EN && take && (in_empty_i == '0) && (pend_q == '0);
  assign sum  = pend_q + n_in;

  // port-level model of stall length and pending bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      pend_q <= '0;
    end else begin
      if (take) pend_q <= (sum >= CNT_W'(LANES)) ? sum - CNT_W'(LANES) : sum;
      if (take && !fast)       busy_q <= n_in;
      else if (busy_q != '0)   busy_q <= busy_q - CNT_W'(1);
    end
  end

  p_stall_after_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !fast) |=> !in_ready_o);

  p_stall_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q != '0) |-> !in_ready_o);

  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q == '0) |-> in_ready_o);

  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast |=> (out_valid_o && in_ready_o && out_data_o == $past(in_data_i)));

  p_valid_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !in_ready_o) |=> !out_valid_o);
endmodule

bind byte_aligner aligner_chk #(
  .LANES    (LANES),
  .BYTE_W   (BYTE_W),
  .BYPASS_EN(BYPASS_EN)
) u_chk (.*);

// File: tb/byte_aligner_tb.sv
module byte_aligner_tb;
  localparam int LANES = 16;
  localparam int BW    = 8;
  localparam int DW    = LANES * BW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic [3:0]    in_empty;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int        errors = 0;
  int        checks = 0;
  int        pend   = 0;
  logic [7:0] seq   = 8'h01;
  logic [7:0] ref_q[$];
  logic       prev_valid = 1'b0;
  logic       prev_ready = 1'b1;

  always #5 clk = ~clk;

  byte_aligner u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .in_data_i  (in_data),
    .in_empty_i (in_empty),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // output monitor: R4 R5 R8 R9 stream compare, R7 strobe spacing
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        logic [DW-1:0] exp_w;
        bit short;
        exp_w = '0;
        short = 1'b0;
        for (int j = 0; j < LANES; j++) begin
          if (ref_q.size() == 0) short = 1'b1;
          else exp_w[j*BW +: BW] = ref_q.pop_front();
        end
        chk(!short && out_data == exp_w, "R4/R5/R8/R9 word", out_data, exp_w);
        if (prev_valid) chk(prev_ready, "R7 strobe gap", DW'(prev_ready), DW'(1));
      end
      prev_valid = out_valid;
      prev_ready = in_ready;
    end
  end

  // called at a negedge; returns at a negedge with in_ready high
  task automatic send(input int n);
    bit fast;
    int stall;
    while (!in_ready) begin
      in_valid = 1'b1;
      in_data  = {$urandom, $urandom, $urandom, $urandom};
      in_empty = 4'($urandom);
      @(negedge clk);
    end
    fast = (n == LANES) && (pend == 0);
    in_data = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < n; i++) begin
      in_data[i*BW +: BW] = seq;
      ref_q.push_back(seq);
      seq = seq + 8'd1;
    end
    in_empty = 4'(LANES - n);
    in_valid = 1'b1;
    @(negedge clk);
    if (fast) chk(out_valid && in_ready, "R6 bypass next cycle",
                  DW'({out_valid, in_ready}), DW'(2'b11));
    else      chk(!in_ready, "R2 ready drops after load", DW'(in_ready), DW'(0));
    stall = 0;
    while (!in_ready && stall < 40) begin
      in_valid = 1'b1;   // R9: offered while not ready, must be ignored
      in_data  = {$urandom, $urandom, $urandom, $urandom};
      in_empty = 4'($urandom);
      stall++;
      @(negedge clk);
    end
    chk(stall == (fast ? 0 : n), "R3 stall length", DW'(stall), DW'(fast ? 0 : n));
    in_valid = 1'b0;
    pend = (pend + n) % LANES;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    in_empty = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1 reset state", DW'({in_ready, out_valid}), DW'(2'b10));

    // full bypass words first, then every pair of byte counts
    send(LANES);
    send(LANES);
    for (int a = 1; a <= LANES; a++) begin
      for (int b = 1; b <= LANES; b++) begin
        send(a);
        send(b);
      end
    end
    repeat (4) @(negedge clk);
    chk(ref_q.size() == pend, "R5 leftover bytes", DW'(ref_q.size()), DW'(pend));
    summary();
  end
endmodule